// File: doc/BRIEF.md
# Four-Channel Memory Transfer Engine

This block moves bytes from one place in memory to another without processor help. It has four channels. Each channel keeps a source address, a destination address, a block length, a repeat count and a mode word. Each address can count up, count down or stay fixed, independently of the other. A channel is armed by a software start bit or by its own trigger line. Each arm moves one burst of 1, 2, 4 or 8 bytes over a byte-wide memory bus that the engine shares with a processor. The engine asks for that bus with a request line and uses it only while the grant is high. Each byte takes one read cycle and then one write cycle.

At the end of a transaction (block length times repeat count bytes) the channel pulses its done line, sets a sticky complete flag and disables itself. It can restore its starting addresses so it is ready for the next run. Channels 0/1 and 2/3 can be linked: when one member of a pair finishes, it enables the other. A peripheral can therefore keep triggering while the two halves of a double buffer swap roles. Bursts are chosen either lowest-index-first or in rotating order.

The sequencer has four states. IDLE (no burst) moves to REQ when any enabled channel has a pending arm, and a channel is picked at that moment. REQ holds the request and moves to RD when the grant is high. RD reads the source byte when granted and moves to WR. WR writes the byte when granted. WR then returns to RD if the burst has bytes left, or to IDLE when the burst or the transaction ends. RD and WR wait in place while the grant is low.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `bus_req`, `mem_re`, `mem_we`, `done`, `complete` and `overflow` are all low.
- R2: Each byte is one cycle with `mem_re` high at the source address, followed by one cycle with `mem_we` high at the destination address carrying the byte read. `mem_re` and `mem_we` are never high together. Configuration: `cfg_reg` 0 = source address, 1 = destination address, 2 = block length, 3 = repeat count (bits 7:0), 4 = control, 7 = engine mode. Control bits: [0] enable, [1] start, [3:2] source mode, [5:4] destination mode, [7:6] burst code, [8] reload, [9] pair link.
- R3: Address mode codes: 0 increments by one after each byte, 1 decrements by one, 2 or 3 keeps the address fixed. Source and destination are chosen separately.
- R4: Burst code k moves 2^k bytes (1, 2, 4, 8) per arm, back to back without another channel in between. A burst ends early when the transaction ends.
- R5: The block length is 16 bits, and the value 0 means 65536 bytes.
- R6: The block is repeated as many times as the 8-bit repeat count says (0 means 256). The transaction ends after block length times repeat count bytes.
- R7: With reload set, the starting source and destination addresses are restored when the transaction ends. With reload clear, the addresses carry on from where they stopped.
- R8: When a transaction ends, that channel's `done` is high for exactly one cycle, its `complete` bit is set and stays set, and its enable is cleared. A write to the control register clears `complete` and `overflow`. At most one `done` bit is high at a time.
- R9: A trigger pulse or start write sets a per-channel pending arm, and the arm is cleared when that channel's burst is picked. An arm that comes while one is still pending is lost and sets `overflow`.
- R10: `mem_re` and `mem_we` are high only while `bus_grant` and `bus_req` are high. `bus_req` stays high from the choice of a burst to its last write.
- R11: Engine mode bit 0 = 0 picks the lowest-index ready channel. Bit 0 = 1 rotates, searching from the channel after the last one served (after reset channel 0 is searched first).
- R12: When a channel with pair link set finishes, its partner (index XOR 1) is enabled. An arm that was pending on the disabled partner then runs.
- R13: A channel runs only while enabled. It is armed equally by the control start bit or by its `trig` line. A trigger on a disabled channel moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_reg | input | 3 | Register selector |
| cfg_wdata | input | 16 | Configuration write data |
| trig | input | 4 | Per-channel trigger pulses |
| bus_req | output | 1 | Memory bus request |
| bus_grant | input | 1 | Memory bus grant |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Read strobe; data returned in the same cycle |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data |
| mem_wdata | output | 8 | Write data |
| done | output | 4 | One-cycle end-of-transaction pulses |
| complete | output | 4 | Sticky end-of-transaction flags |
| overflow | output | 4 | Sticky lost-arm flags |

## Verification
The assertions assume that the grant is only ever given while the request is high, and that it may be withdrawn in any cycle. The stimulus builds the grant from the request gated by a blocking flag, so both the stall path and the normal path are exercised. The assertions also assume that no channel is reconfigured while its burst is in flight. The bench only writes registers while the engine is idle or the target channel is disabled. Triggers are single-cycle pulses. The memory model returns read data in the same cycle, matching the bus contract the engine expects.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int CFG_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } eng_st_e;

    typedef enum logic [2:0] {
        RG_SRC = 3'd0,
        RG_DST = 3'd1,
        RG_BLK = 3'd2,
        RG_REP = 3'd3,
        RG_CTL = 3'd4,
        RG_ENG = 3'd7
    } reg_sel_e;

    // control bits 9:2
    typedef struct packed {
        logic       pair;
        logic       reload;
        logic [1:0] burst;
        logic [1:0] dmode;
        logic [1:0] smode;
    } ch_mode_t;

endpackage

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx
    import dma_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_reg,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             trig,
    input  logic             burst_go,
    input  logic             byte_done,
    input  logic             link_en,
    output logic             ready,
    output logic [AW-1:0]    rd_addr,
    output logic [AW-1:0]    wr_addr,
    output logic [1:0]       burst_code,
    output logic             last_byte,
    output logic             pair_on,
    output logic             done_p,
    output logic             complete,
    output logic             overflow
);

    logic [AW-1:0] base_src, base_dst, cur_src, cur_dst, src_nx, dst_nx;
    logic [CW-1:0] blk_len, cnt_left;
    logic [RW-1:0] rep_cnt, rep_left;
    ch_mode_t      mode;
    logic          en, pend, sw_go, arm, blk_end;

    assign sw_go      = cfg_wr && (reg_sel_e'(cfg_reg) == RG_CTL) && cfg_data[1];
    assign arm        = trig | sw_go;
    assign blk_end    = (cnt_left == CW'(1));
    assign last_byte  = blk_end && (rep_left == RW'(1));
    assign ready      = en & pend;
    assign rd_addr    = cur_src;
    assign wr_addr    = cur_dst;
    assign burst_code = mode.burst;
    assign pair_on    = mode.pair;

    always_comb begin
        unique case (mode.smode)
            2'd0:    src_nx = cur_src + AW'(1);
            2'd1:    src_nx = cur_src - AW'(1);
            default: src_nx = cur_src;
        endcase
        unique case (mode.dmode)
            2'd0:    dst_nx = cur_dst + AW'(1);
            2'd1:    dst_nx = cur_dst - AW'(1);
            default: dst_nx = cur_dst;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_src <= '0; base_dst <= '0; cur_src <= '0; cur_dst <= '0;
            blk_len  <= '0; cnt_left <= '0; rep_cnt <= '0; rep_left <= '0;
            mode     <= '0; en <= 1'b0; pend <= 1'b0;
            done_p   <= 1'b0; complete <= 1'b0; overflow <= 1'b0;
        end else begin
            done_p <= 1'b0;
            pend   <= (pend & ~burst_go) | arm;
            if (cfg_wr) begin
                case (reg_sel_e'(cfg_reg))
                    RG_SRC: begin base_src <= AW'(cfg_data); cur_src <= AW'(cfg_data); end
                    RG_DST: begin base_dst <= AW'(cfg_data); cur_dst <= AW'(cfg_data); end
                    RG_BLK: begin blk_len <= CW'(cfg_data); cnt_left <= CW'(cfg_data); end
                    RG_REP: begin rep_cnt <= RW'(cfg_data); rep_left <= RW'(cfg_data); end
                    RG_CTL: begin
                        en       <= cfg_data[0];
                        mode     <= cfg_data[9:2];
                        complete <= 1'b0;
                        overflow <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (arm && pend && !burst_go)
                overflow <= 1'b1;
            if (byte_done) begin
                cur_src <= src_nx;
                cur_dst <= dst_nx;
                if (blk_end) begin
                    cnt_left <= blk_len;
                    rep_left <= rep_left - RW'(1);
                end else begin
                    cnt_left <= cnt_left - CW'(1);
                end
                if (last_byte) begin
                    rep_left <= rep_cnt;
                    en       <= 1'b0;
                    done_p   <= 1'b1;
                    complete <= 1'b1;
                    if (mode.reload) begin
                        cur_src <= base_src;
                        cur_dst <= base_dst;
                    end
                end
            end
            if (link_en)
                en <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          rr_mode,
    input  logic          take,
    output logic [IW-1:0] pick,
    output logic          any
);

    logic [IW-1:0] last;
    logic          found;

    assign any = |req;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        if (!rr_mode) begin
            for (int k = 0; k < N; k++) begin
                if (req[k] && !found) begin
                    pick  = IW'(k);
                    found = 1'b1;
                end
            end
        end else begin
            for (int k = 1; k <= N; k++) begin
                if (req[(int'(last) + k) % N] && !found) begin
                    pick  = IW'((int'(last) + k) % N);
                    found = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            last <= IW'(N - 1);
        else if (take)
            last <= pick;
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int CW  = 16,
    parameter int RW  = 8,
    localparam int IW  = $clog2(NCH),
    localparam int BLW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_ch,
    input  logic [2:0]       cfg_reg,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NCH-1:0]   trig,
    output logic             bus_req,
    input  logic             bus_grant,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_re,
    output logic             mem_we,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    mem_wdata,
    output logic [NCH-1:0]   done,
    output logic [NCH-1:0]   complete,
    output logic [NCH-1:0]   overflow
);

    eng_st_e        state, state_nx;
    logic [IW-1:0]  sel, pick;
    logic [BLW-1:0] blen_left;
    logic [DW-1:0]  data_q;
    logic           rr_q, any, take;

    logic [AW-1:0]  ch_src [NCH];
    logic [AW-1:0]  ch_dst [NCH];
    logic [1:0]     ch_bc  [NCH];
    logic [NCH-1:0] ch_last, ch_ready, ch_pair, go_vec, step_vec, link_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign link_vec[g] = done[g ^ 1] & ch_pair[g ^ 1];
        dma_chan_ctx #(.AW(AW), .CW(CW), .RW(RW)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_we && (cfg_ch == IW'(g))),
            .cfg_reg   (cfg_reg),
            .cfg_data  (cfg_wdata),
            .trig      (trig[g]),
            .burst_go  (go_vec[g]),
            .byte_done (step_vec[g]),
            .link_en   (link_vec[g]),
            .ready     (ch_ready[g]),
            .rd_addr   (ch_src[g]),
            .wr_addr   (ch_dst[g]),
            .burst_code(ch_bc[g]),
            .last_byte (ch_last[g]),
            .pair_on   (ch_pair[g]),
            .done_p    (done[g]),
            .complete  (complete[g]),
            .overflow  (overflow[g])
        );
    end

    dma_chan_arb #(.N(NCH)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (ch_ready),
        .rr_mode(rr_q),
        .take   (take),
        .pick   (pick),
        .any    (any)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (any)       state_nx = ST_REQ;
            ST_REQ:  if (bus_grant) state_nx = ST_RD;
            ST_RD:   if (bus_grant) state_nx = ST_WR;
            ST_WR:   if (bus_grant)
                         state_nx = (ch_last[sel] || blen_left == BLW'(1)) ? ST_IDLE : ST_RD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sel       <= '0;
            blen_left <= '0;
            data_q    <= '0;
            rr_q      <= 1'b0;
        end else begin
            state <= state_nx;
            if (take) begin
                sel       <= pick;
                blen_left <= BLW'(1) << ch_bc[pick];
            end
            if (state == ST_RD && bus_grant)
                data_q <= mem_rdata;
            if (state == ST_WR && bus_grant)
                blen_left <= blen_left - BLW'(1);
            if (cfg_we && reg_sel_e'(cfg_reg) == RG_ENG)
                rr_q <= cfg_wdata[0];
        end
    end

    always_comb begin
        take      = (state == ST_IDLE) && any;
        go_vec    = take ? (NCH'(1) << pick) : '0;
        bus_req   = (state != ST_IDLE);
        mem_re    = (state == ST_RD) && bus_grant;
        mem_we    = (state == ST_WR) && bus_grant;
        step_vec  = mem_we ? (NCH'(1) << sel) : '0;
        mem_addr  = (state == ST_WR) ? ch_dst[sel] : ch_src[sel];
        mem_wdata = data_q;
    end

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_grant,
    input logic           mem_re,
    input logic           mem_we,
    input logic [NCH-1:0] done
);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R10
    grant_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> bus_grant);

    // R10
    req_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> bus_req);

    // R8
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> ((done & $past(done)) == '0));

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_ch;
    logic [2:0]  cfg_reg;
    logic [15:0] cfg_wdata;
    logic [3:0]  trig;
    logic        bus_req, bus_grant, mem_re, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic [3:0]  done, complete, overflow;
    logic        gnt_block;

    logic [7:0]  mem [256];
    logic [15:0] wlog [16];
    int          wn;
    int          dcnt [4];
    int          checks = 0;
    int          fails  = 0;

    always #2 clk = ~clk;

    assign bus_grant = bus_req & ~gnt_block;
    assign mem_rdata = mem[mem_addr[7:0]];

    dma_xfer_engine u_dma_xfer_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .trig(trig),
        .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .done(done), .complete(complete),
        .overflow(overflow)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            if (wn < 16) wlog[wn] <= mem_addr;
            wn <= wn + 1;
        end
        for (int i = 0; i < 4; i++)
            if (done[i]) dcnt[i] <= dcnt[i] + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic logic [15:0] ctl(input bit en, input bit go, input logic [1:0] sm,
                                        input logic [1:0] dm, input logic [1:0] bl,
                                        input bit rl, input bit pr);
        return {6'b0, pr, rl, bl, dm, sm, go, en};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_reg = '0; cfg_wdata = '0;
        trig = '0; gnt_block = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        wn = 0;
        for (int i = 0; i < 4; i++) dcnt[i] = 0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
    endtask

    task automatic cfg(input logic [1:0] ch, input logic [2:0] rg, input logic [15:0] d);
        cfg_we = 1'b1; cfg_ch = ch; cfg_reg = rg; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [1:0] ch, input int src, input int dst,
                         input int cnt, input int rep);
        cfg(ch, 3'd0, 16'(src));
        cfg(ch, 3'd1, 16'(dst));
        cfg(ch, 3'd2, 16'(cnt));
        cfg(ch, 3'd3, 16'(rep));
    endtask

    task automatic pulse(input logic [3:0] t);
        trig = t;
        @(negedge clk);
        trig = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bus_req", bus_req, 0);
        chk("R1 strobes", {mem_re, mem_we}, 0);
        chk("R1 done", done, 0);
        chk("R1 complete", complete, 0);
        chk("R1 overflow", overflow, 0);
    endtask

    task automatic t_copy();
        do_reset();
        setup(0, 'h10, 'h80, 4, 1);
        cfg(0, 3'd4, ctl(1, 1, 0, 0, 3, 0, 0));
        settle(40);
        for (int k = 0; k < 4; k++) chk("R2 incr copy", mem['h80 + k], pat('h10 + k));
        chk("R8 complete set", complete[0], 1);
        chk("R8 single done pulse", dcnt[0], 1);
        chk("R2 write count", wn, 4);
        mem['h10] = 8'hEE;
        pulse(4'b0001);
        settle(30);
        chk("R13 disabled channel moves nothing", mem['h80], pat('h10));
        chk("R8 complete sticky", complete[0], 1);
    endtask

    task automatic t_modes();
        do_reset();
        setup(1, 'h23, 'h90, 3, 1);
        cfg(1, 3'd4, ctl(1, 1, 1, 0, 2, 0, 0));
        settle(30);
        for (int k = 0; k < 3; k++) chk("R3 decrement source", mem['h90 + k], pat('h23 - k));
        chk("R4 burst stops at end", mem['h93], pat('h93));
        setup(2, 'h30, 'hA8, 3, 1);
        cfg(2, 3'd4, ctl(1, 1, 0, 2, 2, 0, 0));
        settle(30);
        chk("R3 fixed destination", mem['hA8], pat('h32));
        chk("R3 fixed destination neighbour", mem['hA9], pat('hA9));
        setup(3, 'h31, 'hA0, 2, 1);
        cfg(3, 3'd4, ctl(1, 1, 3, 0, 1, 0, 0));
        settle(30);
        chk("R3 fixed source a", mem['hA0], pat('h31));
        chk("R3 fixed source b", mem['hA1], pat('h31));
    endtask

    task automatic t_burst();
        do_reset();
        setup(3, 'h50, 'hC0, 4, 1);
        cfg(3, 3'd4, ctl(1, 0, 0, 0, 1, 0, 0));
        settle(5);
        chk("R13 no run without arm", wn, 0);
        pulse(4'b1000);
        settle(20);
        chk("R4 two-byte burst b0", mem['hC0], pat('h50));
        chk("R4 two-byte burst b1", mem['hC1], pat('h51));
        chk("R4 burst length", mem['hC2], pat('hC2));
        chk("R8 not yet complete", complete[3], 0);
        pulse(4'b1000);
        settle(20);
        chk("R13 trigger second burst", mem['hC3], pat('h53));
        chk("R8 complete after last", complete[3], 1);
        setup(0, 'h00, 'hE0, 0, 1);
        cfg(0, 3'd4, ctl(1, 1, 0, 0, 3, 0, 0));
        settle(40);
        chk("R5 zero length moves full burst", mem['hE7], pat('h07));
        chk("R5 burst bounded", mem['hE8], pat('hE8));
        chk("R5 zero length not done", complete[0], 0);
    endtask

    task automatic t_repeat();
        do_reset();
        setup(1, 'h40, 'hB0, 2, 3);
        cfg(1, 3'd4, ctl(1, 0, 0, 0, 1, 1, 0));
        pulse(4'b0010); settle(15);
        pulse(4'b0010); settle(15);
        chk("R6 mid transaction", complete[1], 0);
        pulse(4'b0010); settle(15);
        chk("R6 complete after repeats", complete[1], 1);
        for (int k = 0; k < 6; k++) chk("R6 repeated data", mem['hB0 + k], pat('h40 + k));
        mem['h40] = 8'h99; mem['h41] = 8'h98;
        cfg(1, 3'd4, ctl(1, 1, 0, 0, 1, 1, 0));
        settle(15);
        chk("R7 reload source/dest a", mem['hB0], 8'h99);
        chk("R7 reload source/dest b", mem['hB1], 8'h98);
        setup(2, 'h60, 'hD8, 1, 1);
        cfg(2, 3'd4, ctl(1, 1, 0, 0, 0, 0, 0));
        settle(10);
        cfg(2, 3'd4, ctl(1, 1, 0, 0, 0, 0, 0));
        settle(10);
        chk("R7 no reload first", mem['hD8], pat('h60));
        chk("R7 no reload continues", mem['hD9], pat('h61));
    endtask

    task automatic t_overflow();
        do_reset();
        gnt_block = 1'b1;
        setup(1, 'h70, 'hF0, 4, 1);
        cfg(1, 3'd4, ctl(1, 0, 0, 0, 0, 0, 0));
        pulse(4'b0010); settle(3);
        pulse(4'b0010); settle(3);
        chk("R9 no overflow yet", overflow[1], 0);
        pulse(4'b0010); settle(3);
        chk("R9 overflow on lost arm", overflow[1], 1);
        chk("R10 request held", bus_req, 1);
        chk("R10 no write without grant", wn, 0);
        gnt_block = 1'b0;
        settle(20);
        chk("R9 first burst", mem['hF0], pat('h70));
        chk("R9 second burst", mem['hF1], pat('h71));
        chk("R9 lost arm moved nothing", mem['hF2], pat('hF2));
        chk("R9 not complete", complete[1], 0);
        cfg(1, 3'd4, ctl(0, 0, 0, 0, 0, 0, 0));
        settle(1);
        chk("R8 control write clears overflow", overflow[1], 0);
    endtask

    task automatic t_prio(input bit rr);
        do_reset();
        cfg(0, 3'd7, 16'(rr));
        gnt_block = 1'b1;
        setup(0, 'h20, 'hC0, 2, 1);
        cfg(0, 3'd4, ctl(1, 0, 0, 0, 0, 0, 0));
        setup(1, 'h28, 'hD0, 2, 1);
        cfg(1, 3'd4, ctl(1, 0, 0, 0, 0, 0, 0));
        pulse(4'b0011); settle(4);
        pulse(4'b0001); settle(3);
        gnt_block = 1'b0;
        settle(30);
        chk(rr ? "R11 rotate first" : "R11 fixed first", wlog[0], 16'hC0);
        chk(rr ? "R11 rotate second" : "R11 fixed second", wlog[1], rr ? 16'hD0 : 16'hC1);
        chk(rr ? "R11 rotate third" : "R11 fixed third", wlog[2], rr ? 16'hC1 : 16'hD0);
    endtask

    task automatic t_pair();
        do_reset();
        setup(2, 'h10, 'h80, 2, 1);
        cfg(2, 3'd4, ctl(0, 0, 0, 0, 1, 1, 1));
        setup(3, 'h20, 'h88, 2, 1);
        cfg(3, 3'd4, ctl(0, 0, 0, 0, 1, 1, 1));
        pulse(4'b1000);
        settle(10);
        chk("R13 disabled partner idle", mem['h88], pat('h88));
        cfg(2, 3'd4, ctl(1, 1, 0, 0, 1, 1, 1));
        settle(30);
        chk("R12 first half", mem['h81], pat('h11));
        chk("R12 handover runs partner", mem['h88], pat('h20));
        chk("R12 partner second byte", mem['h89], pat('h21));
        chk("R12 partner done", dcnt[3], 1);
        mem['h10] = 8'h77;
        pulse(4'b0100);
        settle(15);
        chk("R12 handover back re-enables", mem['h80], 8'h77);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_copy();
        t_modes();
        t_burst();
        t_repeat();
        t_overflow();
        t_prio(1'b0);
        t_prio(1'b1);
        t_pair();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule